// File: doc/BRIEF.md
# Word Load/Store Address Unit

This block executes the memory half of word load and word store instructions in a small 32-bit RISC core. When `issue` is high in its idle state, it decodes the instruction word. The caller supplies the contents of the base register and the register to be stored, and the block reports which base register index the instruction names. The block adds the sign-extended 16-bit offset to the base value to form a byte address, then checks that the address falls on a word boundary. A legal access goes out on a word-wide memory port with a valid/ready handshake. A load returns the memory word with its destination register index one cycle after the memory accepts the read.

An access whose address is not a multiple of the word size is not truncated and not sent to memory. It raises a fault pulse of one cycle instead. The block issues no request and produces no load result for it. Opcodes other than the word load and the word store pass through with no effect.

The control is a four-state machine. `ST_IDLE` waits for `issue`. It moves to `ST_REQ` for an aligned load or store, moves to `ST_FAULT` for a misaligned one, and stays in `ST_IDLE` for any other opcode. `ST_REQ` drives the memory request until `mem_ready`. It then goes to `ST_RESP` for a load and back to `ST_IDLE` for a store. `ST_RESP` presents the load result for one cycle and returns to `ST_IDLE`. `ST_FAULT` raises `fault` for one cycle and returns to `ST_IDLE`.

Top module: `lsu_addr_unit`

## Requirements
- R1: The instruction fields are opcode = instr[31:26], base register index = instr[25:21] (driven on `base_idx` at all times), data register index = instr[20:16] and offset = instr[15:0].
- R2: The byte address is `base` plus the offset sign-extended to 32 bits, wrapping modulo 2^32, so a negative offset reaches below the base.
- R3: Opcode 35 is a word load. In the cycle after issue, `mem_valid`=1 and `mem_we`=0 at the computed address. In the cycle after a handshake (`mem_valid` and `mem_ready` both high), `ld_valid` is high for exactly one cycle, with `ld_data` equal to the accepted `mem_rdata` and `ld_rd` equal to the data register index.
- R4: Opcode 43 is a word store. In the cycle after issue, `mem_valid`=1, `mem_we`=1 and `mem_wdata` equals `st_data`. A store never raises `ld_valid`.
- R5: An access is legal only when the address is a multiple of 4. A load or store with address bits [1:0] not zero raises `fault` for exactly one cycle, in the cycle after issue. It asserts no `mem_valid` and no `ld_valid`.
- R6: Any opcode other than 35 and 43 produces no request, no fault and no `busy`.
- R7: While `mem_valid` is high and `mem_ready` is low, the request and its address, write enable and write data stay unchanged.
- R8: After reset, `mem_valid`, `mem_we`, `ld_valid`, `fault` and `busy` are 0. Reset in the middle of a request drops it at once.
- R9: `issue` is ignored while `busy` is high. A second instruction during an outstanding access changes neither the request nor the load result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction present, sampled in idle |
| instr | input | 32 | Instruction word |
| base | input | 32 | Contents of the base register |
| st_data | input | 32 | Contents of the data register, for stores |
| base_idx | output | 5 | Base register index decoded from `instr` |
| busy | output | 1 | Access in progress, `issue` ignored |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, sampled at the handshake |
| ld_valid | output | 1 | Load result valid, one cycle |
| ld_data | output | 32 | Loaded word |
| ld_rd | output | 5 | Destination register index |
| fault | output | 1 | Misaligned-access pulse |

## Verification
The assertions check protocol invariants on every cycle. They confirm that a request holds steady until it is accepted and never carries a misaligned address. They also confirm that `fault` and `ld_valid` last exactly one cycle, that a load result appears only after an accepted read, and that a fault never coincides with a request. The bench scenarios cover the rest. These include the address arithmetic, with negative offsets, both ends of the offset range and wrap past 2^32, and the correct destination index and data. They also cover the silent handling of foreign opcodes, the rejection of a second instruction while busy, and the dropping of a request by reset.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int OPC_W  = 6;
    localparam int REG_W  = 5;
    localparam int IMM_W  = 16;

    localparam logic [OPC_W-1:0] OPC_LOAD_W  = 6'd35;
    localparam logic [OPC_W-1:0] OPC_STORE_W = 6'd43;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_RESP,
        ST_FAULT
    } lsu_state_t;

    typedef struct packed {
        logic             is_load;
        logic             is_store;
        logic [REG_W-1:0] base_reg;
        logic [REG_W-1:0] data_reg;
        logic [IMM_W-1:0] offset;
    } lsu_dec_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] instr,
    output lsu_dec_t        dec
);
    localparam int OPC_LSB  = XLEN - OPC_W;
    localparam int BASE_LSB = OPC_LSB - REG_W;
    localparam int DATA_LSB = BASE_LSB - REG_W;

    logic [OPC_W-1:0] opcode;

    always_comb begin
        opcode       = instr[OPC_LSB +: OPC_W];
        dec.base_reg = instr[BASE_LSB +: REG_W];
        dec.data_reg = instr[DATA_LSB +: REG_W];
        dec.offset   = instr[IMM_W-1:0];
        dec.is_load  = (opcode == OPC_LOAD_W);
        dec.is_store = (opcode == OPC_STORE_W);
    end
endmodule

// File: rtl/lsu_ea_calc.sv
module lsu_ea_calc
    import lsu_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] offset,
    output logic [XLEN-1:0]  ea,
    output logic             misaligned
);
    localparam int ALIGN_BITS = $clog2(WORD_BYTES);
    localparam int EXT_W      = XLEN - IMM_W;

    logic [XLEN-1:0] offset_sx;

    always_comb begin
        offset_sx = {{EXT_W{offset[IMM_W-1]}}, offset};
        ea        = base + offset_sx;
    end

    generate
        if (ALIGN_BITS == 0) begin : g_byte_words
            assign misaligned = 1'b0;
        end else begin : g_word_check
            assign misaligned = |ea[ALIGN_BITS-1:0];
        end
    endgenerate
endmodule

// File: rtl/lsu_addr_unit.sv
module lsu_addr_unit
    import lsu_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   base,
    input  logic [XLEN-1:0]   st_data,
    output logic [REG_W-1:0]  base_idx,
    output logic              busy,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [XLEN-1:0]   mem_addr,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              ld_valid,
    output logic [XLEN-1:0]   ld_data,
    output logic [REG_W-1:0]  ld_rd,
    output logic              fault
);
    localparam logic [XLEN-1:0] ALIGN_MASK = XLEN'(WORD_BYTES - 1);

    lsu_dec_t        dec;
    logic [XLEN-1:0] ea;
    logic            misaligned;
    lsu_state_t      state_q, state_d;

    logic [XLEN-1:0]  addr_q, wdata_q, rdata_q;
    logic             we_q;
    logic [REG_W-1:0] rd_q;

    lsu_decode #(.XLEN(XLEN)) u_decode (
        .instr (instr),
        .dec   (dec)
    );

    lsu_ea_calc #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_ea (
        .base       (base),
        .offset     (dec.offset),
        .ea         (ea),
        .misaligned (misaligned)
    );

    logic accept_new;
    logic mem_hs;
    assign accept_new = issue && (state_q == ST_IDLE) && (dec.is_load || dec.is_store);
    assign mem_hs     = (state_q == ST_REQ) && mem_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept_new) state_d = misaligned ? ST_FAULT : ST_REQ;
            ST_REQ:   if (mem_ready)  state_d = we_q ? ST_IDLE : ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // access registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            rd_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (accept_new && !misaligned) begin
                addr_q  <= ea;
                wdata_q <= st_data;
                we_q    <= dec.is_store;
                if (dec.is_load) rd_q <= dec.data_reg;
            end
            if (mem_hs && !we_q) rdata_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        base_idx  = dec.base_reg;
        busy      = (state_q != ST_IDLE);
        mem_valid = (state_q == ST_REQ);
        mem_we    = (state_q == ST_REQ) && we_q;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        ld_valid  = (state_q == ST_RESP);
        ld_data   = rdata_q;
        ld_rd     = rd_q;
        fault     = (state_q == ST_FAULT);
    end

    // R7: request held steady until accepted
    a_r7_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_we) && $stable(mem_wdata)));

    // R5: no request ever carries a misaligned address
    a_r5_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((mem_addr & ALIGN_MASK) == '0));

    // R5: fault is a single-cycle pulse with no request
    a_r5_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);
    a_r5_fault_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_valid && !ld_valid));

    // R3: load result follows an accepted read and lasts one cycle
    a_r3_ld_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_valid && mem_ready && !mem_we));
    a_r3_ld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid);

    // R4: an accepted write produces no load result
    a_r4_store_no_ld: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_we) |=> !ld_valid);
endmodule

// File: tb/lsu_addr_unit_tb_top.sv
`timescale 1ns/1ps
module lsu_addr_unit_tb_top;
    localparam int NV = 12;
    localparam logic [31:0] RKEY = 32'h5A5A_0F0F;

    // kind: 0 load, 1 store, 2 fault, 3 no effect
    localparam logic [5:0]  V_OPC  [NV] = '{6'd35, 6'd35, 6'd43, 6'd43, 6'd35, 6'd35,
                                            6'd35, 6'd43, 6'd35, 6'd0, 6'd8, 6'd34};
    localparam logic [4:0]  V_RS   [NV] = '{5'd18, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5,
                                            5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11};
    localparam logic [4:0]  V_RT   [NV] = '{5'd9, 5'd3, 5'd5, 5'd7, 5'd12, 5'd31,
                                            5'd1, 5'd2, 5'd4, 5'd6, 5'd8, 5'd10};
    localparam logic [15:0] V_IMM  [NV] = '{16'h0020, 16'hFFFC, 16'h0008, 16'h8000,
                                            16'h7FFC, 16'h0004, 16'h0001, 16'h0002,
                                            16'h0000, 16'h0010, 16'h0010, 16'h0010};
    localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h0000_0100, 32'h0000_2000,
                                            32'h0001_0000, 32'h0000_0000, 32'hFFFF_FFFC,
                                            32'h0000_1000, 32'h0000_1000, 32'h0000_1003,
                                            32'h0000_1000, 32'h0000_1000, 32'h0000_1000};
    localparam logic [31:0] V_SD   [NV] = '{32'h0, 32'h0, 32'hDEAD_BEEF, 32'h1234_5678,
                                            32'h0, 32'h0, 32'h0, 32'hCAFE_0001,
                                            32'h0, 32'h0, 32'h0, 32'h0};
    localparam logic [31:0] V_EA   [NV] = '{32'h0000_1020, 32'h0000_00FC, 32'h0000_2008,
                                            32'h0000_8000, 32'h0000_7FFC, 32'h0000_0000,
                                            32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam int          V_KIND [NV] = '{0, 0, 1, 1, 0, 0, 2, 2, 2, 3, 3, 3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] instr = '0, base = '0, st_data = '0;
    logic        mem_ready = 1'b0;
    logic [4:0]  base_idx, ld_rd;
    logic        busy, mem_valid, mem_we, ld_valid, fault;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data;

    int checks = 0;
    int fails  = 0;
    int n_writes = 0;
    logic [31:0] w_addr = '0, w_data = '0;

    always #2 clk = ~clk;

    assign mem_rdata = mem_addr ^ RKEY;

    always @(posedge clk)
        if (mem_valid && mem_ready && mem_we) begin
            n_writes = n_writes + 1;
            w_addr   = mem_addr;
            w_data   = mem_wdata;
        end

    lsu_addr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .base(base),
        .st_data(st_data), .base_idx(base_idx), .busy(busy), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
        .ld_data(ld_data), .ld_rd(ld_rd), .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic drive(input logic [5:0] opc, input logic [4:0] rs, input logic [4:0] rt,
                         input logic [15:0] imm, input logic [31:0] b, input logic [31:0] sd);
        instr   = {opc, rs, rt, imm};
        base    = b;
        st_data = sd;
        issue   = 1'b1;
    endtask

    initial begin
        #40000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(!mem_valid && !mem_we && !ld_valid && !fault && !busy, "R8 reset outputs",
            {27'd0, mem_valid, mem_we, ld_valid, fault, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            int wr0;
            wr0 = n_writes;
            drive(V_OPC[i], V_RS[i], V_RT[i], V_IMM[i], V_BASE[i], V_SD[i]);
            #0;
            // R1: base register index
            #1 chk(base_idx == V_RS[i], "R1 base_idx", {27'd0, base_idx}, {27'd0, V_RS[i]});
            @(negedge clk);
            issue = 1'b0;
            if (V_KIND[i] <= 1) begin
                // R2/R3/R4: request with computed address
                chk(mem_valid && mem_addr == V_EA[i], "R2 request address", mem_addr, V_EA[i]);
                chk(mem_we == (V_KIND[i] == 1), "R3 R4 write enable", {31'd0, mem_we},
                    {31'd0, V_KIND[i] == 1});
                if (V_KIND[i] == 1)
                    chk(mem_wdata == V_SD[i], "R4 store data", mem_wdata, V_SD[i]);
                if (i % 2 == 1) begin
                    @(negedge clk);
                    chk(mem_valid && mem_addr == V_EA[i], "R7 held while not ready",
                        mem_addr, V_EA[i]);
                end
                mem_ready = 1'b1;
                @(negedge clk);
                mem_ready = 1'b0;
                if (V_KIND[i] == 0) begin
                    chk(ld_valid, "R3 ld_valid", {31'd0, ld_valid}, 32'd1);
                    chk(ld_data == (V_EA[i] ^ RKEY), "R3 ld_data", ld_data, V_EA[i] ^ RKEY);
                    chk(ld_rd == V_RT[i], "R3 ld_rd", {27'd0, ld_rd}, {27'd0, V_RT[i]});
                end else begin
                    chk(!ld_valid, "R4 no load result", {31'd0, ld_valid}, 32'd0);
                    chk(n_writes == wr0 + 1 && w_addr == V_EA[i] && w_data == V_SD[i],
                        "R4 write landed", w_data, V_SD[i]);
                end
                @(negedge clk);
                chk(!ld_valid && !busy, "R3 result one cycle", {30'd0, ld_valid, busy}, 32'd0);
            end else if (V_KIND[i] == 2) begin
                chk(fault && !mem_valid, "R5 fault no request",
                    {30'd0, fault, mem_valid}, 32'd2);
                @(negedge clk);
                chk(!fault && !mem_valid && !ld_valid && !busy, "R5 fault one cycle",
                    {28'd0, fault, mem_valid, ld_valid, busy}, 32'd0);
                chk(n_writes == wr0, "R5 no write", n_writes, wr0);
            end else begin
                chk(!mem_valid && !fault && !busy, "R6 foreign opcode ignored",
                    {29'd0, mem_valid, fault, busy}, 32'd0);
                @(negedge clk);
                chk(!mem_valid && !ld_valid, "R6 stays idle",
                    {30'd0, mem_valid, ld_valid}, 32'd0);
            end
        end

        // R9: second instruction while busy is ignored
        begin
            int wr0;
            wr0 = n_writes;
            drive(6'd35, 5'd2, 5'd9, 16'h0040, 32'h0000_3000, 32'h0);
            @(negedge clk);
            drive(6'd43, 5'd3, 5'd4, 16'h0000, 32'h0000_5000, 32'h7777_7777);
            @(negedge clk);
            issue = 1'b0;
            chk(mem_valid && !mem_we && mem_addr == 32'h0000_3040, "R9 request unchanged",
                mem_addr, 32'h0000_3040);
            mem_ready = 1'b1;
            @(negedge clk);
            mem_ready = 1'b0;
            chk(ld_valid && ld_rd == 5'd9 && ld_data == (32'h0000_3040 ^ RKEY),
                "R9 load result kept", ld_data, 32'h0000_3040 ^ RKEY);
            @(negedge clk);
            chk(!busy && !mem_valid && n_writes == wr0, "R9 no extra access",
                {31'd0, busy}, 32'd0);
        end

        // R8: reset mid-request drops it
        drive(6'd43, 5'd1, 5'd2, 16'h0004, 32'h0000_4000, 32'h1111_2222);
        @(negedge clk);
        issue = 1'b0;
        chk(mem_valid, "R8 request before reset", {31'd0, mem_valid}, 32'd1);
        rst_n = 1'b0;
        #1 chk(!mem_valid && !busy && !mem_we, "R8 reset drops request",
               {29'd0, mem_valid, busy, mem_we}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_valid && !busy, "R8 idle after reset", {30'd0, mem_valid, busy}, 32'd0);

        summary();
    end
endmodule